// File: doc/BRIEF.md
# Peak Current Setpoint Arbiter

This block turns the regulation loop's two control-law codes into the peak current threshold for the next switching cycle, in millivolt units for the current comparator DAC. The lower of the constant-voltage and constant-current requests is selected and divided by the current setpoint ratio. A floor depends on the compensation-node level and protects light-load operation. A startup ramp caps the result, and a fixed ceiling bounds it. A slow triangular dither is then added to spread switching noise.

The valley sequencer supplies a foldback flag, which silences the dither, and a strobe once per switching cycle. The threshold register loads only on that strobe. A startup request restarts the ramp from its lower bound. All arithmetic is on unsigned millivolt codes and saturates.

Top module: `pk_setpoint_arbiter`

## Requirements
- R1: While reset is asserted and after its release, `thr_mv` reads 0 until the first `cycle_tick`. The startup ramp begins at 250 mV on reset release.
- R2: The active law is the smaller of `cv_law` and `cc_law`. The raw setpoint is that value divided by 4, rounded down.
- R3: `thr_mv` loads only on a clock edge where `cycle_tick` is 1, with the value from that edge's inputs. It is readable one clock later and holds at all other times.
- R4: `ss_restart` returns the ramp to 250 mV. The ramp then rises by 1 mV every `SS_STEP_CLKS` clocks and stops at 800 mV. The threshold never exceeds the ramp plus the dither.
- R5: With `comp_mv` at or above 760, the floor is 250 mV.
- R6: With `comp_mv` below 260, the floor is 65 mV.
- R7: For 260 <= `comp_mv` < 760, the floor is 65 + floor((comp_mv-260)*185/500) mV. The threshold is the larger of this floor and the raw setpoint before the ramp cap.
- R8: After the dither is added, the threshold is clamped to at most 800 mV.
- R9: With `foldback` low, a triangle running 0..60 mV in 1 mV steps, one step per `JIT_STEP_CLKS` clocks, is added to the capped setpoint.
- R10: While `foldback` is high, the dither is held at 0 and the threshold equals the capped setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cv_law | input | MV_W | Constant-voltage control-law code, mV |
| cc_law | input | MV_W | Constant-current control-law code, mV |
| comp_mv | input | MV_W | Compensation-node level, mV |
| ss_restart | input | 1 | Restart the soft-start ramp |
| foldback | input | 1 | Frequency foldback active; silences dither |
| cycle_tick | input | 1 | Per-switching-cycle load strobe |
| thr_mv | output | MV_W | Peak current threshold, mV |

## Verification
The threshold is registered on the tick edge, so every check drives the inputs with `cycle_tick` on a falling edge and reads `thr_mv` on the next falling edge. That is exactly one clock after the load. A restart affects the ramp at the next rising edge, so a tick on that same edge still uses the old ramp. For this reason, ramp checks tick one clock after the restart. The dither advances every clock in the bench configuration, so dither checks compare the range of values seen over a full period against the band the requirements give. They do not predict exact per-cycle samples.

// File: rtl/pk_pkg.sv
package pk_pkg;
  parameter int unsigned MV_W = 12;
  typedef logic [MV_W-1:0] mv_t;

  function automatic mv_t mv_min(input mv_t a, input mv_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic mv_t mv_max(input mv_t a, input mv_t b);
    return (a > b) ? a : b;
  endfunction

  // Saturating add of two millivolt codes.
  function automatic mv_t mv_sat_add(input mv_t a, input mv_t b);
    logic [MV_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[MV_W] ? {MV_W{1'b1}} : s[MV_W-1:0];
  endfunction

  // Light-load floor: low floor below lo_knee, high floor at or above hi_knee,
  // linear blend (rounded down) in between.
  function automatic mv_t blend_floor(input mv_t comp, input int unsigned lo_knee,
                                      input int unsigned hi_knee, input int unsigned lo_mv,
                                      input int unsigned hi_mv);
    int unsigned c;
    int unsigned f;
    c = int'(comp);
    if (c >= hi_knee) f = hi_mv;
    else if (c < lo_knee) f = lo_mv;
    else f = lo_mv + ((c - lo_knee) * (hi_mv - lo_mv)) / (hi_knee - lo_knee);
    return mv_t'(f);
  endfunction
endpackage

// File: rtl/pk_ss_ramp.sv
module pk_ss_ramp
  import pk_pkg::*;
#(
  parameter int unsigned STEP_CLKS = 1455,
  parameter int unsigned LO_MV     = 250,
  parameter int unsigned HI_MV     = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output mv_t  ramp_mv
);
  localparam int unsigned PW = $clog2(STEP_CLKS + 1);
  localparam logic [PW-1:0] PLAST = PW'(STEP_CLKS - 1);

  logic [PW-1:0] presc;
  logic          ramp_top;

  assign ramp_top = (ramp_mv >= mv_t'(HI_MV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      ramp_mv <= mv_t'(LO_MV);
    end else if (restart) begin
      presc   <= '0;
      ramp_mv <= mv_t'(LO_MV);
    end else if (!ramp_top) begin
      if (presc == PLAST) begin
        presc   <= '0;
        ramp_mv <= ramp_mv + mv_t'(1);
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end

  AST_RAMP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ramp_mv == mv_t'(LO_MV)) else $error("ramp restart"); // R4
  AST_RAMP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (ramp_mv >= $past(ramp_mv)) && (ramp_mv <= mv_t'(HI_MV))) else $error("ramp mono"); // R4
endmodule

// File: rtl/pk_jitter_tri.sv
module pk_jitter_tri
  import pk_pkg::*;
#(
  parameter int unsigned STEP_CLKS = 1111,
  parameter int unsigned PP_MV     = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output mv_t  jit_mv
);
  localparam int unsigned PW = $clog2(STEP_CLKS + 1);
  localparam logic [PW-1:0] PLAST = PW'(STEP_CLKS - 1);

  logic [PW-1:0] presc;
  logic          rising;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      jit_mv <= '0;
      rising <= 1'b1;
    end else if (hold) begin
      presc  <= '0;
      jit_mv <= '0;
      rising <= 1'b1;
    end else if (presc == PLAST) begin
      presc <= '0;
      if (rising) begin
        jit_mv <= jit_mv + mv_t'(1);
        if (jit_mv + mv_t'(1) == mv_t'(PP_MV)) rising <= 1'b0;
      end else begin
        jit_mv <= jit_mv - mv_t'(1);
        if (jit_mv == mv_t'(1)) rising <= 1'b1;
      end
    end else begin
      presc <= presc + PW'(1);
    end
  end

  AST_JIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> jit_mv == '0) else $error("jitter hold"); // R10
  AST_JIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    jit_mv <= mv_t'(PP_MV)) else $error("jitter range"); // R9
endmodule

// File: rtl/pk_setpoint_arbiter.sv
module pk_setpoint_arbiter
  import pk_pkg::*;
#(
  parameter int unsigned LAW_DIV       = 4,
  parameter int unsigned SS_STEP_CLKS  = 1455,
  parameter int unsigned JIT_STEP_CLKS = 1111,
  parameter int unsigned SS_LO_MV      = 250,
  parameter int unsigned CEIL_MV       = 800,
  parameter int unsigned FLOOR_HI_MV   = 250,
  parameter int unsigned FLOOR_LO_MV   = 65,
  parameter int unsigned COMP_HI_MV    = 760,
  parameter int unsigned COMP_LO_MV    = 260,
  parameter int unsigned JIT_PP_MV     = 60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] cv_law,
  input  logic [MV_W-1:0] cc_law,
  input  logic [MV_W-1:0] comp_mv,
  input  logic            ss_restart,
  input  logic            foldback,
  input  logic            cycle_tick,
  output logic [MV_W-1:0] thr_mv
);
  mv_t ramp_mv, jit_mv;
  mv_t law_sel, raw_mv, floor_mv, floored_mv, capped_mv, dithered_mv, next_thr;

  pk_ss_ramp #(.STEP_CLKS(SS_STEP_CLKS), .LO_MV(SS_LO_MV), .HI_MV(CEIL_MV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .restart(ss_restart), .ramp_mv(ramp_mv));

  pk_jitter_tri #(.STEP_CLKS(JIT_STEP_CLKS), .PP_MV(JIT_PP_MV)) u_jit (
    .clk(clk), .rst_n(rst_n), .hold(foldback), .jit_mv(jit_mv));

  always_comb begin
    law_sel     = mv_min(cv_law, cc_law);
    raw_mv      = law_sel / mv_t'(LAW_DIV);
    floor_mv    = blend_floor(comp_mv, COMP_LO_MV, COMP_HI_MV, FLOOR_LO_MV, FLOOR_HI_MV);
    floored_mv  = mv_max(raw_mv, floor_mv);
    capped_mv   = mv_min(floored_mv, ramp_mv);
    dithered_mv = mv_sat_add(capped_mv, jit_mv);
    next_thr    = mv_min(dithered_mv, mv_t'(CEIL_MV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_mv <= '0;
    else if (cycle_tick) thr_mv <= next_thr;
  end

  AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    thr_mv <= mv_t'(CEIL_MV)) else $error("ceiling"); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_tick |=> $stable(thr_mv)) else $error("hold"); // R3
  AST_RAMP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick |=> thr_mv <= mv_sat_add($past(ramp_mv), $past(jit_mv))) else $error("ramp cap"); // R4
  AST_FLOOR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick && (comp_mv >= mv_t'(COMP_HI_MV)) |=> thr_mv >= mv_t'(FLOOR_HI_MV)) else $error("floor"); // R5
endmodule

// File: tb/test_pk_setpoint_arbiter.sv
module test_pk_setpoint_arbiter;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cv_law = '0, cc_law = '0, comp_mv = '0;
  logic ss_restart = 1'b0, foldback = 1'b1, cycle_tick = 1'b0;
  logic [W-1:0] thr_mv;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pk_setpoint_arbiter #(.SS_STEP_CLKS(2), .JIT_STEP_CLKS(1)) i_pk_setpoint_arbiter (
    .clk(clk), .rst_n(rst_n), .cv_law(cv_law), .cc_law(cc_law), .comp_mv(comp_mv),
    .ss_restart(ss_restart), .foldback(foldback), .cycle_tick(cycle_tick), .thr_mv(thr_mv));

  // cv, cc, comp, expected (ramp finished, foldback high)
  localparam logic [47:0] VEC [13] = '{
    {12'd2000, 12'd3000, 12'd2000, 12'd500},  // R2 lower law wins
    {12'd3000, 12'd1203, 12'd2000, 12'd300},  // R2 truncation
    {12'd400,  12'd4000, 12'd1000, 12'd250},  // R5
    {12'd100,  12'd100,  12'd100,  12'd65},   // R6
    {12'd0,    12'd0,    12'd259,  12'd65},   // R6 edge
    {12'd0,    12'd0,    12'd260,  12'd65},   // R7 low knee
    {12'd0,    12'd0,    12'd510,  12'd157},  // R7 mid
    {12'd0,    12'd0,    12'd759,  12'd249},  // R7 top
    {12'd0,    12'd0,    12'd760,  12'd250},  // R5 knee
    {12'd480,  12'd480,  12'd400,  12'd120},  // R7 raw above floor
    {12'd4095, 12'd4095, 12'd3000, 12'd800},  // R8
    {12'd3300, 12'd4000, 12'd3000, 12'd800},  // R8
    {12'd3196, 12'd3196, 12'd3000, 12'd799}   // R8 below ceiling
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_load(input int cv, input int cc, input int cp);
    @(negedge clk);
    cv_law = W'(cv); cc_law = W'(cc); comp_mv = W'(cp); cycle_tick = 1'b1;
    @(negedge clk);
    cycle_tick = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo, hi, prev;
    bit bad;
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(thr_mv), 0);
    cv_law = 12'd4000; cc_law = 12'd4000; comp_mv = 12'd3000;
    rst_n = 1'b1;
    cycle_tick = 1'b1;
    @(negedge clk);
    cycle_tick = 1'b0;
    chk("R1 ramp start", int'(thr_mv), 250);
    repeat (1200) @(negedge clk);
    // R3: input change without tick leaves output alone
    cv_law = 12'd400; cc_law = 12'd400; comp_mv = 12'd3000;
    repeat (3) @(negedge clk);
    chk("R3 hold", int'(thr_mv), 250);
    tick_load(2000, 2000, 3000);
    chk("R3 load", int'(thr_mv), 500);

    for (int i = 0; i < 13; i++) begin
      tick_load(int'(VEC[i][47:36]), int'(VEC[i][35:24]), int'(VEC[i][23:12]));
      chk($sformatf("R2/R5/R6/R7/R8 vec%0d", i), int'(thr_mv), int'(VEC[i][11:0]));
    end

    // R4: restart, then ramp rises monotonically to 800
    @(negedge clk);
    ss_restart = 1'b1;
    @(negedge clk);
    ss_restart = 1'b0;
    tick_load(4000, 4000, 3000);
    chk("R4 restart", int'(thr_mv), 250);
    prev = 250; bad = 1'b0;
    cycle_tick = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (int'(thr_mv) < prev || int'(thr_mv) > 800) bad = 1'b1;
      prev = int'(thr_mv);
    end
    chk("R4 mono", int'(bad), 0);
    chk("R4 midway", int'(prev > 250 && prev < 800), 1);
    repeat (900) @(negedge clk);
    chk("R4 top", int'(thr_mv), 800);

    // R9: dither band 500..560
    cv_law = 12'd2000; cc_law = 12'd2000; foldback = 1'b0;
    repeat (3) @(negedge clk);
    lo = 4095; hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (int'(thr_mv) < lo) lo = int'(thr_mv);
      if (int'(thr_mv) > hi) hi = int'(thr_mv);
    end
    chk("R9 min", lo, 500);
    chk("R9 max", hi, 560);

    // R8: dither clamped at ceiling
    cv_law = 12'd3120; cc_law = 12'd3120;
    lo = 4095; hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (int'(thr_mv) < lo) lo = int'(thr_mv);
      if (int'(thr_mv) > hi) hi = int'(thr_mv);
    end
    chk("R8 dither min", lo, 780);
    chk("R8 dither max", hi, 800);

    // R10: foldback silences dither
    cv_law = 12'd2000; cc_law = 12'd2000; foldback = 1'b1;
    repeat (3) @(negedge clk);
    bad = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (thr_mv != 12'd500) bad = 1'b1;
    end
    chk("R10 foldback", int'(bad), 0);
    cycle_tick = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule